// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block programs one phase-locked loop through two register images: a base image holding the input divider, feedback multiplier, post-divider and the enable, bypass and override controls, and a misc image holding the charge-pump code. A request carries the four divider and charge-pump values together with the oscillator rate in kHz. The block then writes the registers in a safe order. The loop runs in bypass while its dividers change, is then enabled, and only after that leaves bypass. A serial divider computes the nominal output rate. A lock timer holds the ready flag low until the stabilisation delay has passed.

A parameter selects the peripheral-loop variant. In that variant, a loop whose override bit is already set is treated as configured by earlier firmware. The block does not rewrite it. It compares the image the request would produce against what is already programmed and reports the result. Any mismatch clears a sticky valid flag. The analog loop and the register fabric are outside the block, so both registers appear as plain outputs, each with a one-cycle write strobe.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, pll_ready is 0 and valid_flag is 1. base_q equals BASE_RST (default 32'h0100_0000) and misc_q equals MISC_RST (default 32'h0004_0500). A request is taken when req_valid and req_ready are both high. busy then stays high and req_ready low until the cycle in which done pulses.
- R2: The first base write replaces M in bits [4:0], N in bits [17:8] and P in bits [22:20], and sets the bypass bit 31. Every other base bit keeps its previous value.
- R3: The second write goes to misc. It puts the charge-pump code into bits [11:8] and leaves all other misc bits unchanged.
- R4: A programming run makes exactly four writes, in the order base, misc, base, base. The third write adds the enable bit 30 to the first image. The fourth write clears bit 31 and changes nothing else.
- R5: In the peripheral variant, when override bit 28 is clear in base_q, the first write also sets bit 28.
- R6: In the peripheral variant, when bit 28 is already set, no write happens. If the new image with bit 30 set equals base_q and valid_flag is still 1, status reports 1 (already correct).
- R7: In the same check path, a mismatch clears valid_flag, and valid_flag never rises again. While valid_flag is 0, every check reports status 2 (error), even for a matching image. base_q, pll_ready and rate_khz remain unchanged.
- R8: In the plain variant, bit 28 is never examined or written. Every request, including a repeated identical one, runs the full four-write sequence.
- R9: After a programming run, rate_khz equals floor(osc_khz × N / (M << P)).
- R10: pll_ready drops at the first base write. It rises no sooner than STABLE_US × CLKS_PER_US cycles after the final base write, in the same cycle as done with status 0.
- R11: done is a one-cycle pulse. status holds 0 (programmed), 1 (already correct) or 2 (error) from that pulse until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_m | input | M_W | Input divider |
| req_n | input | N_W | Feedback multiplier |
| req_p | input | P_W | Post-divider exponent |
| req_cp | input | CP_W | Charge-pump code |
| osc_khz | input | OSC_W | Reference oscillator rate in kHz |
| base_q | output | REG_W | Base register image |
| misc_q | output | REG_W | Misc register image |
| base_wr | output | 1 | Base register written this cycle |
| misc_wr | output | 1 | Misc register written this cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one-cycle pulse) |
| status | output | 2 | Result code of the last request |
| valid_flag | output | 1 | Sticky flag, cleared on a check mismatch |
| pll_ready | output | 1 | Loop output usable |
| rate_khz | output | OSC_W+N_W | Nominal output rate in kHz |

## Verification
A sequencer state that skips or repeats a step appears on the write strobes within one cycle. It shows as a missing misc write, an enable write without bypass held, or a fifth base write, and the bench records the strobes in order. A wrong merge mask appears in the register image of that same write, because the bench predicts every written value from the previous image. A lock counter that ends early raises pll_ready too soon after the final base write. A valid flag that recovers on its own turns a later error report into "already correct".

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    STAT_PROGRAMMED = 2'd0,
    STAT_ALREADY_OK = 2'd1,
    STAT_ERROR      = 2'd2
  } pll_status_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CHECK, SQ_MISC, SQ_ENAB, SQ_UNBYP, SQ_RATE, SQ_LOCK
  } seq_state_e;
endpackage

// File: rtl/pll_img_build.sv
module pll_img_build #(
  parameter int REG_W  = 32,
  parameter int M_W    = 5,
  parameter int M_LSB  = 0,
  parameter int N_W    = 10,
  parameter int N_LSB  = 8,
  parameter int P_W    = 3,
  parameter int P_LSB  = 20,
  parameter int CP_W   = 4,
  parameter int CP_LSB = 8
) (
  input  logic [REG_W-1:0] base_cur,
  input  logic [REG_W-1:0] misc_cur,
  input  logic [M_W-1:0]   m_val,
  input  logic [N_W-1:0]   n_val,
  input  logic [P_W-1:0]   p_val,
  input  logic [CP_W-1:0]  cp_val,
  output logic [REG_W-1:0] base_img,
  output logic [REG_W-1:0] misc_img
);
  localparam logic [REG_W-1:0] ONE     = REG_W'(1);
  localparam logic [REG_W-1:0] M_MASK  = ((ONE << M_W) - ONE) << M_LSB;
  localparam logic [REG_W-1:0] N_MASK  = ((ONE << N_W) - ONE) << N_LSB;
  localparam logic [REG_W-1:0] P_MASK  = ((ONE << P_W) - ONE) << P_LSB;
  localparam logic [REG_W-1:0] CP_MASK = ((ONE << CP_W) - ONE) << CP_LSB;
  localparam logic [REG_W-1:0] DIV_MASK = M_MASK | N_MASK | P_MASK;

  // Field merge: clear the owned bits, then insert the new values.
  always_comb begin
    base_img = (base_cur & ~DIV_MASK)
             | ((REG_W'(m_val) << M_LSB) & M_MASK)
             | ((REG_W'(n_val) << N_LSB) & N_MASK)
             | ((REG_W'(p_val) << P_LSB) & P_MASK);
    misc_img = (misc_cur & ~CP_MASK) | ((REG_W'(cp_val) << CP_LSB) & CP_MASK);
  end
endmodule

// File: rtl/pll_rate_div.sv
module pll_rate_div #(
  parameter int NUM_W = 34,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q, rem_nx;
  logic [DEN_W:0]   rem_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, ge;

  // One restoring step per cycle, quotient bits shift in from the right.
  always_comb begin
    rem_sh = {rem_q, quo[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    rem_nx = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      done  <= 1'b0;
      cnt_q <= CNT_W'(NUM_W);
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        done  <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      quo   <= num;
      rem_q <= '0;
      den_q <= den;
    end else if (run_q) begin
      quo   <= {quo[NUM_W-2:0], ge};
      rem_q <= rem_nx;
    end
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      cnt_q   <= '0;
      run_q   <= 1'b1;
      expired <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == CW'(CYCLES - 1)) begin
        run_q   <= 1'b0;
        expired <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      expired <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int OSC_W       = 24,
  parameter int M_W         = 5,
  parameter int M_LSB       = 0,
  parameter int N_W         = 10,
  parameter int N_LSB       = 8,
  parameter int P_W         = 3,
  parameter int P_LSB       = 20,
  parameter int CP_W        = 4,
  parameter int CP_LSB      = 8,
  parameter int BYP_BIT     = 31,
  parameter int EN_BIT      = 30,
  parameter int OVR_BIT     = 28,
  parameter logic [REG_W-1:0] BASE_RST = 32'h0100_0000,
  parameter logic [REG_W-1:0] MISC_RST = 32'h0004_0500,
  parameter int PERIPH_PLL  = 0,
  parameter int STABLE_US   = 300,
  parameter int CLKS_PER_US = 1,
  localparam int NUM_W      = OSC_W + N_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [M_W-1:0]   req_m,
  input  logic [N_W-1:0]   req_n,
  input  logic [P_W-1:0]   req_p,
  input  logic [CP_W-1:0]  req_cp,
  input  logic [OSC_W-1:0] osc_khz,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] misc_q,
  output logic             base_wr,
  output logic             misc_wr,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             valid_flag,
  output logic             pll_ready,
  output logic [NUM_W-1:0] rate_khz
);
  localparam int DEN_W       = M_W + (1 << P_W) - 1;
  localparam int LOCK_CYCLES = STABLE_US * CLKS_PER_US;
  localparam logic [REG_W-1:0] BYP_MASK = REG_W'(1) << BYP_BIT;
  localparam logic [REG_W-1:0] EN_MASK  = REG_W'(1) << EN_BIT;
  localparam logic [REG_W-1:0] OVR_MASK = REG_W'(1) << OVR_BIT;

  seq_state_e  state_q, state_d;
  pll_status_e status_q, status_d;
  logic [REG_W-1:0] base_d, misc_d, base_img, misc_img, ovr_add;
  logic bwr_d, mwr_d, done_d, valid_d, rdy_d;
  logic cap_en, div_start, div_done, lock_start, lock_exp, ovr_seen, match_w;
  logic [M_W-1:0]   m_q;
  logic [N_W-1:0]   n_q;
  logic [P_W-1:0]   p_q;
  logic [CP_W-1:0]  cp_q;
  logic [OSC_W-1:0] osc_q;
  logic [NUM_W-1:0] quo;

  pll_img_build #(
    .REG_W(REG_W), .M_W(M_W), .M_LSB(M_LSB), .N_W(N_W), .N_LSB(N_LSB),
    .P_W(P_W), .P_LSB(P_LSB), .CP_W(CP_W), .CP_LSB(CP_LSB)
  ) u_img (
    .base_cur(base_q), .misc_cur(misc_q), .m_val(m_q), .n_val(n_q),
    .p_val(p_q), .cp_val(cp_q), .base_img(base_img), .misc_img(misc_img)
  );

  pll_rate_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(NUM_W'(osc_q) * NUM_W'(n_q)),
    .den(DEN_W'(m_q) << p_q),
    .done(div_done), .quo(quo)
  );

  pll_lock_timer #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(lock_start), .expired(lock_exp)
  );

  // Variant select: only the peripheral loop honours a preset override bit.
  generate
    if (PERIPH_PLL != 0) begin : g_periph
      assign ovr_seen = base_q[OVR_BIT];
      assign ovr_add  = OVR_MASK;
    end else begin : g_plain
      assign ovr_seen = 1'b0;
      assign ovr_add  = '0;
    end
  endgenerate

  assign match_w   = ((base_img | EN_MASK) == base_q);
  assign cap_en    = (state_q == SQ_IDLE) && req_valid;
  assign req_ready = (state_q == SQ_IDLE);
  assign busy      = (state_q != SQ_IDLE);
  assign status    = status_q;

  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    misc_d     = misc_q;
    bwr_d      = 1'b0;
    mwr_d      = 1'b0;
    done_d     = 1'b0;
    status_d   = status_q;
    valid_d    = valid_flag;
    rdy_d      = pll_ready;
    div_start  = 1'b0;
    lock_start = 1'b0;
    case (state_q)
      SQ_IDLE: if (req_valid) state_d = SQ_CHECK;
      SQ_CHECK: begin
        if (ovr_seen) begin
          valid_d  = valid_flag & match_w;
          status_d = (valid_flag && match_w) ? STAT_ALREADY_OK : STAT_ERROR;
          done_d   = 1'b1;
          state_d  = SQ_IDLE;
        end else begin
          base_d  = base_img | BYP_MASK | ovr_add;
          bwr_d   = 1'b1;
          rdy_d   = 1'b0;
          state_d = SQ_MISC;
        end
      end
      SQ_MISC: begin
        misc_d  = misc_img;
        mwr_d   = 1'b1;
        state_d = SQ_ENAB;
      end
      SQ_ENAB: begin
        base_d  = base_q | EN_MASK;
        bwr_d   = 1'b1;
        state_d = SQ_UNBYP;
      end
      SQ_UNBYP: begin
        base_d    = base_q & ~BYP_MASK;
        bwr_d     = 1'b1;
        div_start = 1'b1;
        state_d   = SQ_RATE;
      end
      SQ_RATE: if (div_done) begin
        lock_start = 1'b1;
        state_d    = SQ_LOCK;
      end
      SQ_LOCK: if (lock_exp) begin
        rdy_d    = 1'b1;
        status_d = STAT_PROGRAMMED;
        done_d   = 1'b1;
        state_d  = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      base_q     <= BASE_RST;
      misc_q     <= MISC_RST;
      base_wr    <= 1'b0;
      misc_wr    <= 1'b0;
      done       <= 1'b0;
      status_q   <= STAT_PROGRAMMED;
      valid_flag <= 1'b1;
      pll_ready  <= 1'b0;
    end else begin
      state_q    <= state_d;
      base_q     <= base_d;
      misc_q     <= misc_d;
      base_wr    <= bwr_d;
      misc_wr    <= mwr_d;
      done       <= done_d;
      status_q   <= status_d;
      valid_flag <= valid_d;
      pll_ready  <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      m_q   <= req_m;
      n_q   <= req_n;
      p_q   <= req_p;
      cp_q  <= req_cp;
      osc_q <= osc_khz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rate_khz <= '0;
    else if (div_done) rate_khz <= quo;
  end
endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk #(
  parameter int REG_W       = 32,
  parameter int BYP_BIT     = 31,
  parameter int EN_BIT      = 30,
  parameter int CP_LSB      = 8,
  parameter int CP_W        = 4,
  parameter int LOCK_CYCLES = 300
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [REG_W-1:0] base_q,
  input logic [REG_W-1:0] misc_q,
  input logic             base_wr,
  input logic             misc_wr,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic             valid_flag,
  input logic             pll_ready
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [REG_W-1:0] CP_MASK = ((REG_W'(1) << CP_W) - REG_W'(1)) << CP_LSB;

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= '0;
    else if (base_wr && !base_q[BYP_BIT]) since_q <= '0;
    else if (since_q != CW'(LOCK_CYCLES)) since_q <= since_q + CW'(1);
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
  // R3
  misc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |-> ($past(base_wr) && base_q[BYP_BIT]));
  // R3
  misc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |-> (((misc_q ^ $past(misc_q)) & ~CP_MASK) == '0));
  // R4
  enable_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (base_wr && base_q[EN_BIT] && base_q[BYP_BIT]));
  // R4
  unbypass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && !base_q[BYP_BIT]) |-> ($past(base_wr) && $past(base_q[EN_BIT]) && $past(base_q[BYP_BIT])));
  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_flag |-> $past(valid_flag));
  // R10
  lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready) |-> (since_q >= CW'(LOCK_CYCLES)));
  // R10
  ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready) |-> (done && status == 2'd0));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pll_prog_seq pll_prog_seq_chk #(
  .REG_W(REG_W), .BYP_BIT(BYP_BIT), .EN_BIT(EN_BIT), .CP_LSB(CP_LSB),
  .CP_W(CP_W), .LOCK_CYCLES(STABLE_US * CLKS_PER_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .base_q(base_q), .misc_q(misc_q), .base_wr(base_wr), .misc_wr(misc_wr),
  .busy(busy), .done(done), .status(status), .valid_flag(valid_flag),
  .pll_ready(pll_ready)
);

// File: tb/tb_pll_prog_seq.sv
module tb_pll_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 300;
  localparam int NUMW = 34;
  localparam logic [31:0] BASE_RST = 32'h0100_0000;
  localparam logic [31:0] MISC_RST = 32'h0004_0500;
  localparam logic [31:0] BYP = 32'h8000_0000;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] OVR = 32'h1000_0000;
  localparam logic [31:0] FMASK = 32'h0073_FF1F;
  localparam logic [31:0] CPMASK = 32'h0000_0F00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic va = 1'b0, vb = 1'b0;
  logic [4:0] rm = '0;
  logic [9:0] rn = '0;
  logic [2:0] rp = '0;
  logic [3:0] rc = '0;
  logic [23:0] rosc = '0;
  logic sel = 1'b0;

  logic rdy_a, rdy_b, bw_a, bw_b, mw_a, mw_b, bsy_a, bsy_b, dn_a, dn_b;
  logic vf_a, vf_b, pr_a, pr_b;
  logic [31:0] base_a, base_b, misc_a, misc_b;
  logic [1:0] st_a, st_b;
  logic [NUMW-1:0] rate_a, rate_b;

  logic o_rdy, o_bw, o_mw, o_bsy, o_dn, o_vf, o_pr;
  logic [31:0] o_base, o_misc;
  logic [1:0] o_st;
  logic [NUMW-1:0] o_rate;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_prog_seq #(.PERIPH_PLL(1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(rdy_a),
    .req_m(rm), .req_n(rn), .req_p(rp), .req_cp(rc), .osc_khz(rosc),
    .base_q(base_a), .misc_q(misc_a), .base_wr(bw_a), .misc_wr(mw_a),
    .busy(bsy_a), .done(dn_a), .status(st_a), .valid_flag(vf_a),
    .pll_ready(pr_a), .rate_khz(rate_a));

  pll_prog_seq #(.PERIPH_PLL(0)) dut_plain (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rdy_b),
    .req_m(rm), .req_n(rn), .req_p(rp), .req_cp(rc), .osc_khz(rosc),
    .base_q(base_b), .misc_q(misc_b), .base_wr(bw_b), .misc_wr(mw_b),
    .busy(bsy_b), .done(dn_b), .status(st_b), .valid_flag(vf_b),
    .pll_ready(pr_b), .rate_khz(rate_b));

  always_comb begin
    o_rdy  = sel ? rdy_b  : rdy_a;
    o_bw   = sel ? bw_b   : bw_a;
    o_mw   = sel ? mw_b   : mw_a;
    o_bsy  = sel ? bsy_b  : bsy_a;
    o_dn   = sel ? dn_b   : dn_a;
    o_vf   = sel ? vf_b   : vf_a;
    o_pr   = sel ? pr_b   : pr_a;
    o_base = sel ? base_b : base_a;
    o_misc = sel ? misc_b : misc_a;
    o_st   = sel ? st_b   : st_a;
    o_rate = sel ? rate_b : rate_a;
  end

  int n_chk = 0, n_fail = 0;
  int nev, wait_cnt, busy_seen;
  int ev_kind [8];
  logic [31:0] ev_val [8];
  logic rdy_at_first;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Issues one request and records every write strobe until done.
  task automatic run_req(input logic s, input int m, input int n, input int p,
                         input int cp, input int osc);
    bit run_seen;
    sel = s;
    @(negedge clk);
    while (!o_rdy) @(negedge clk);
    rm = 5'(m); rn = 10'(n); rp = 3'(p); rc = 4'(cp); rosc = 24'(osc);
    if (s) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    va = 1'b0; vb = 1'b0;
    busy_seen = int'(o_bsy && !o_rdy);
    nev = 0; wait_cnt = 0; run_seen = 0; rdy_at_first = 1'b1;
    for (int c = 0; c < 5000; c++) begin
      if (run_seen) wait_cnt++;
      if (o_bw || o_mw) begin
        if (nev < 8) begin
          ev_kind[nev] = o_bw ? 1 : 2;
          ev_val[nev]  = o_bw ? o_base : o_misc;
        end
        if (nev == 0) rdy_at_first = o_pr;
        if (o_bw && !o_base[31]) begin run_seen = 1; wait_cnt = 0; end
        nev++;
      end
      if (o_dn) break;
      @(negedge clk);
    end
  endtask

  task automatic prog_case(input logic s, input bit periph, input int m, input int n,
                           input int p, input int cp, input int osc);
    logic [31:0] bb, mb, e1, fields;
    longint er;
    int order;
    bb = o_base; mb = o_misc;
    sel = s; #1; bb = o_base; mb = o_misc;
    fields = (32'(m) & 32'h1F) | ((32'(n) & 32'h3FF) << 8) | ((32'(p) & 32'h7) << 20);
    e1 = (bb & ~FMASK) | fields | BYP | (periph ? OVR : 32'h0);
    er = (longint'(osc) * longint'(n)) / (longint'(m) << p);
    run_req(s, m, n, p, cp, osc);
    check(busy_seen == 1, "R1 busy after accept", busy_seen, 1);
    order = (nev == 4) ? ev_kind[0]*1000 + ev_kind[1]*100 + ev_kind[2]*10 + ev_kind[3] : nev;
    check(order == 1211, "R4 write order", order, 1211);
    if (nev == 4) begin
      check(ev_val[0] == e1, periph ? "R2/R5 first base image" : "R2 R8 first base image", ev_val[0], e1);
      check(ev_val[1] == ((mb & ~CPMASK) | (32'(cp) << 8)), "R3 misc image",
            ev_val[1], (mb & ~CPMASK) | (32'(cp) << 8));
      check(ev_val[2] == (e1 | EN), "R4 enable image", ev_val[2], e1 | EN);
      check(ev_val[3] == ((e1 | EN) & ~BYP), "R4 run image", ev_val[3], (e1 | EN) & ~BYP);
    end
    check(rdy_at_first == 1'b0, "R10 ready dropped", rdy_at_first, 0);
    check(wait_cnt >= LOCK && wait_cnt <= LOCK + NUMW + 4, "R10 lock wait", wait_cnt, LOCK);
    check(o_dn && o_st == 2'd0 && o_pr, "R11 programmed status", {o_dn, o_pr, o_st}, 4'b1100);
    check(longint'(o_rate) == er, "R9 rate", o_rate, er);
    @(negedge clk);
    check(!o_dn && o_rdy && !o_bsy, "R11 done single pulse R1 idle", {o_dn, o_rdy, o_bsy}, 3'b010);
  endtask

  task automatic check_case(input int m, input int n, input int p, input int cp,
                            input int osc, input int exp_st, input logic exp_vf, input string tag);
    logic [31:0] bb; logic pb; logic [NUMW-1:0] rb;
    sel = 1'b0; #1;
    bb = o_base; pb = o_pr; rb = o_rate;
    run_req(1'b0, m, n, p, cp, osc);
    check(nev == 0, {tag, " no writes"}, nev, 0);
    check(o_dn && int'(o_st) == exp_st, {tag, " status"}, o_st, exp_st);
    check(o_vf == exp_vf, {tag, " valid flag"}, o_vf, exp_vf);
    check(o_base == bb && o_pr == pb && o_rate == rb, {tag, " state kept"}, o_base, bb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, both variants
    check(rdy_a && !bsy_a && !pr_a && vf_a, "R1 reset flags", {rdy_a, bsy_a, pr_a, vf_a}, 4'b1001);
    check(base_a == BASE_RST && misc_a == MISC_RST, "R1 reset images", base_a, BASE_RST);
    check(base_b == BASE_RST && misc_b == MISC_RST, "R1 reset images plain", misc_b, MISC_RST);
    // R5: peripheral loop programmed with override added
    prog_case(1'b0, 1'b1, 12, 408, 0, 8, 12000);
    // R6: same request finds the loop already correct
    check_case(12, 408, 0, 8, 12000, 1, 1'b1, "R6 match");
    // R7: mismatch, then sticky error on a matching request
    check_case(12, 400, 0, 8, 12000, 2, 1'b0, "R7 mismatch");
    check_case(12, 408, 0, 8, 12000, 2, 1'b0, "R7 sticky");
    // R8: plain variant reprograms every time
    prog_case(1'b1, 1'b0, 13, 600, 1, 8, 13000);
    prog_case(1'b1, 1'b0, 13, 600, 1, 8, 13000);
    check(base_b[28] == 1'b0, "R8 override untouched", base_b[28], 0);
    // R9: truncating rate and a shifted denominator
    prog_case(1'b1, 1'b0, 7, 13, 0, 3, 12000);
    prog_case(1'b1, 1'b0, 3, 100, 2, 15, 19200);
    summary();
    $finish;
  end
endmodule